// File: doc/BRIEF.md
# Exception Mode and Banked Stack-Pointer Controller

This block keeps the execution-mode, privilege and stack-pointer state of a small processor core while exceptions are taken and returned from. It has two banked stack pointers: a main pointer and a process pointer. The active pointer is chosen from the current mode and a two-bit control register. Bit 0 of that register drops privilege and bit 1 selects the process pointer in Thread mode.

When an exception is accepted, the block switches to Handler mode and raises privilege. It then issues eight consecutive word writes that form the exception frame on the stack that was active before entry. It also moves that pointer down to the frame's lowest word. A return request carries a two-bit code that picks the mode and pointer to resume with. Both pointers can be read and written directly through dedicated ports. The memory that receives the frame and the register values that fill it sit outside the block.

Top module: `exc_sp_ctrl`

## Requirements
- R1: After reset the block is in Thread mode (`handler_mode`=0), is privileged, has a control value of 00, shows the main pointer (reset value `MSP_RESET`) on `sp_active`, and has `busy`, `push_we` and `ret_err` low.
- R2: An accepted exception makes `handler_mode` 1 and `privileged` 1 in the next cycle. In Handler mode `sp_active` always equals the main pointer.
- R3: From the cycle after acceptance, `busy` and `push_we` are high for exactly eight cycles. `push_slot` counts 0 to 7 in register order R0, R1, R2, R3, R12, LR, PC, PSR. `push_addr` equals `base + 4*slot`, where `base` is the pointer that was active before entry minus 32.
- R4: In the first cycle after stacking, the pointer that was used holds `base` and the other pointer is unchanged.
- R5: In Thread mode, control bit 1 selects the process pointer (1) or the main pointer (0). A control write made while privileged and not busy takes effect in the next cycle, in Thread or in Handler mode.
- R6: Writing control bit 0 as 1 makes Thread mode unprivileged. Control writes made while unprivileged are ignored. Privilege returns only by taking an exception.
- R7: A return request in Handler mode applies its code in the next cycle. Code 00 stays in Handler mode. Code 01 enters Thread mode with control bit 1 cleared. Code 10 enters Thread mode with control bit 1 set. Returns leave both pointer values unchanged.
- R8: Return code 11 raises `ret_err` for one cycle and leaves the mode, privilege and pointer selection unchanged.
- R9: An exception request made while `busy` is high is absorbed into the current entry. It produces no further frame and moves no pointer.
- R10: An exception request in the same cycle as an applied valid return (tail-chaining) produces no frame and keeps Handler mode.
- R11: A return request made while `busy` is high is held. It is applied in the cycle after `busy` falls, so Handler mode persists through the first non-busy cycle.
- R12: `msp_out` and `psp_out` show both pointers at all times. Written values have their two low bits forced to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception request |
| ret_req | input | 1 | Exception-return request |
| ret_code | input | 2 | Return code (00 handler, 01 thread/main, 10 thread/process, 11 invalid) |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Control write data: bit 0 unprivileged, bit 1 process pointer select |
| msp_we | input | 1 | Main pointer write strobe |
| psp_we | input | 1 | Process pointer write strobe |
| sp_wdata | input | 32 | Pointer write data |
| msp_out | output | 32 | Main pointer value |
| psp_out | output | 32 | Process pointer value |
| sp_active | output | 32 | Currently active pointer value |
| handler_mode | output | 1 | 1 in Handler mode, 0 in Thread mode |
| privileged | output | 1 | Current privilege |
| busy | output | 1 | Frame stacking in progress |
| push_we | output | 1 | Frame word write strobe |
| push_addr | output | 32 | Frame word address |
| push_slot | output | 3 | Frame word index (0=R0 ... 7=PSR) |
| ret_err | output | 1 | One-cycle pulse on an invalid return code |

## Verification
Two pairs of functions can fall in the same cycle. The first is an exception request together with a return request in Handler mode. The bench drives both in one cycle and judges the outcome at the ports: `busy` must stay low, the mode must stay Handler and the main pointer must keep its value. The second is a request that arrives while stacking is under way. The bench raises an exception request and, separately, a return request partway through the eight push cycles. It then checks that the frame count and the pointer drop stay at one frame, and that the held return changes the mode exactly one cycle after `busy` falls.

// File: rtl/exc_sp_pkg.sv
package exc_sp_pkg;
  localparam int SP_W        = 32;
  localparam int FRAME_WORDS = 8;
  localparam int WORD_BYTES  = 4;
  localparam int SLOT_W      = $clog2(FRAME_WORDS);
  localparam int FRAME_BYTES = FRAME_WORDS * WORD_BYTES;

  typedef enum logic [1:0] {
    RET_HANDLER     = 2'b00,
    RET_THREAD_MAIN = 2'b01,
    RET_THREAD_PROC = 2'b10,
    RET_BAD         = 2'b11
  } ret_code_e;

  // lowest address of a frame pushed below sp
  function automatic logic [SP_W-1:0] frame_base(input logic [SP_W-1:0] sp);
    return sp - SP_W'(FRAME_BYTES);
  endfunction

  // address of one frame word
  function automatic logic [SP_W-1:0] slot_addr(input logic [SP_W-1:0] base,
                                                input logic [SLOT_W-1:0] slot);
    return base + SP_W'(slot) * SP_W'(WORD_BYTES);
  endfunction

  // force word alignment
  function automatic logic [SP_W-1:0] word_align(input logic [SP_W-1:0] v);
    return v & ~SP_W'(WORD_BYTES - 1);
  endfunction
endpackage

// File: rtl/exc_sp_bank.sv
module exc_sp_bank
  import exc_sp_pkg::*;
#(
  parameter logic [SP_W-1:0] MSP_RESET = 32'h2000_0400
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            msp_we_i,
  input  logic            psp_we_i,
  input  logic [SP_W-1:0] wdata_i,
  input  logic            upd_en_i,
  input  logic            upd_psp_i,
  input  logic [SP_W-1:0] upd_val_i,
  output logic [SP_W-1:0] msp_o,
  output logic [SP_W-1:0] psp_o
);
  localparam int NBANK = 2;

  logic [SP_W-1:0] sp_q  [NBANK];
  logic            wr_en [NBANK];
  logic [SP_W-1:0] rst_v [NBANK];

  assign wr_en[0] = msp_we_i;
  assign wr_en[1] = psp_we_i;
  assign rst_v[0] = word_align(MSP_RESET);
  assign rst_v[1] = '0;

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    logic upd_hit;
    assign upd_hit = upd_en_i && (upd_psp_i == (i == 1));
    // frame update wins over an explicit write in the same cycle
    always_ff @(posedge clk) begin
      if (!rst_n)         sp_q[i] <= rst_v[i];
      else if (upd_hit)   sp_q[i] <= upd_val_i;
      else if (wr_en[i])  sp_q[i] <= word_align(wdata_i);
    end
  end

  assign msp_o = sp_q[0];
  assign psp_o = sp_q[1];
endmodule

// File: rtl/exc_sp_stacker.sv
module exc_sp_stacker
  import exc_sp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              use_psp_i,
  input  logic [SP_W-1:0]   sp_i,
  output logic              busy_o,
  output logic              push_we_o,
  output logic [SP_W-1:0]   push_addr_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              upd_en_o,
  output logic              upd_psp_o,
  output logic [SP_W-1:0]   upd_val_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_WORDS - 1);

  logic              busy_q;
  logic [SLOT_W-1:0] cnt_q;
  logic [SP_W-1:0]   base_q;
  logic              onpsp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      base_q  <= '0;
      onpsp_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST_SLOT) busy_q <= 1'b0;
    end else if (take_i) begin
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      base_q  <= frame_base(sp_i);
      onpsp_q <= use_psp_i;
    end
  end

  assign busy_o      = busy_q;
  assign push_we_o   = busy_q;
  assign push_addr_o = slot_addr(base_q, cnt_q);
  assign slot_o      = cnt_q;
  assign upd_en_o    = busy_q && (cnt_q == LAST_SLOT);
  assign upd_psp_o   = onpsp_q;
  assign upd_val_o   = base_q;
endmodule

// File: rtl/exc_sp_mode.sv
module exc_sp_mode
  import exc_sp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exc_req_i,
  input  logic       ret_req_i,
  input  logic [1:0] ret_code_i,
  input  logic       ctl_we_i,
  input  logic [1:0] ctl_wdata_i,
  input  logic       busy_i,
  output logic       handler_o,
  output logic [1:0] ctl_o,
  output logic       take_o,
  output logic       tail_o,
  output logic       ret_err_o
);
  logic       handler_q;
  logic [1:0] ctl_q;
  logic       pend_q;
  logic [1:0] pend_code_q;
  logic       err_q;

  logic       ret_in, eff_ret, code_ok, ret_do, ctl_do, priv;
  logic [1:0] eff_code;

  always_comb begin
    ret_in   = ret_req_i && handler_q;
    eff_ret  = !busy_i && (pend_q || ret_in);
    eff_code = pend_q ? pend_code_q : ret_code_i;
    code_ok  = ret_code_e'(eff_code) != RET_BAD;
    tail_o   = exc_req_i && eff_ret && code_ok;
    take_o   = exc_req_i && !busy_i && !tail_o;
    ret_do   = eff_ret && code_ok && !exc_req_i;
    priv     = handler_q || !ctl_q[0];
    ctl_do   = ctl_we_i && priv && !busy_i && !exc_req_i && !eff_ret;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      handler_q   <= 1'b0;
      ctl_q       <= 2'b00;
      pend_q      <= 1'b0;
      pend_code_q <= 2'b00;
      err_q       <= 1'b0;
    end else begin
      err_q <= eff_ret && !code_ok;
      if (busy_i) begin
        if (ret_in) begin
          pend_q      <= 1'b1;
          pend_code_q <= ret_code_i;
        end
      end else begin
        pend_q <= 1'b0;
      end
      if (take_o) begin
        handler_q <= 1'b1;
      end else if (ret_do) begin
        case (ret_code_e'(eff_code))
          RET_THREAD_MAIN: begin handler_q <= 1'b0; ctl_q[1] <= 1'b0; end
          RET_THREAD_PROC: begin handler_q <= 1'b0; ctl_q[1] <= 1'b1; end
          default: ;
        endcase
      end else if (ctl_do) begin
        ctl_q <= ctl_wdata_i;
      end
    end
  end

  assign handler_o = handler_q;
  assign ctl_o     = ctl_q;
  assign ret_err_o = err_q;
endmodule

// File: rtl/exc_sp_ctrl.sv
module exc_sp_ctrl
  import exc_sp_pkg::*;
#(
  parameter logic [SP_W-1:0] MSP_RESET = 32'h2000_0400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req,
  input  logic              ret_req,
  input  logic [1:0]        ret_code,
  input  logic              ctl_we,
  input  logic [1:0]        ctl_wdata,
  input  logic              msp_we,
  input  logic              psp_we,
  input  logic [SP_W-1:0]   sp_wdata,
  output logic [SP_W-1:0]   msp_out,
  output logic [SP_W-1:0]   psp_out,
  output logic [SP_W-1:0]   sp_active,
  output logic              handler_mode,
  output logic              privileged,
  output logic              busy,
  output logic              push_we,
  output logic [SP_W-1:0]   push_addr,
  output logic [SLOT_W-1:0] push_slot,
  output logic              ret_err
);
  // named internal events
  logic            take_exc;
  logic            tail_chain;
  logic            psp_sel;
  logic            stack_done;
  logic            upd_psp;
  logic [SP_W-1:0] upd_val;
  logic [1:0]      ctl;

  exc_sp_mode u_mode (
    .clk, .rst_n,
    .exc_req_i(exc_req), .ret_req_i(ret_req), .ret_code_i(ret_code),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .busy_i(busy),
    .handler_o(handler_mode), .ctl_o(ctl),
    .take_o(take_exc), .tail_o(tail_chain), .ret_err_o(ret_err)
  );

  assign psp_sel    = !handler_mode && ctl[1];
  assign privileged = handler_mode || !ctl[0];
  assign sp_active  = psp_sel ? psp_out : msp_out;

  exc_sp_stacker u_stack (
    .clk, .rst_n,
    .take_i(take_exc), .use_psp_i(psp_sel), .sp_i(sp_active),
    .busy_o(busy), .push_we_o(push_we), .push_addr_o(push_addr), .slot_o(push_slot),
    .upd_en_o(stack_done), .upd_psp_o(upd_psp), .upd_val_o(upd_val)
  );

  exc_sp_bank #(.MSP_RESET(MSP_RESET)) u_bank (
    .clk, .rst_n,
    .msp_we_i(msp_we), .psp_we_i(psp_we), .wdata_i(sp_wdata),
    .upd_en_i(stack_done), .upd_psp_i(upd_psp), .upd_val_i(upd_val),
    .msp_o(msp_out), .psp_o(psp_out)
  );
endmodule

// File: rtl/exc_sp_ctrl_chk.sv
module exc_sp_ctrl_chk
  import exc_sp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              take_exc,
  input logic              tail_chain,
  input logic              busy,
  input logic [SLOT_W-1:0] push_slot,
  input logic [SP_W-1:0]   push_addr,
  input logic              handler_mode,
  input logic              privileged,
  input logic [SP_W-1:0]   sp_active,
  input logic [SP_W-1:0]   msp_out,
  input logic [SP_W-1:0]   psp_out,
  input logic              ret_err
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_WORDS - 1);
  localparam logic [SP_W-1:0]   TOP_OFS = SP_W'((FRAME_WORDS - 1) * WORD_BYTES);

  // R2
  handler_msp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    handler_mode |-> sp_active == msp_out);
  // R2
  entry_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> handler_mode && privileged);
  // R3
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> busy && push_slot == '0);
  // R3
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && push_slot != LAST |=> busy && push_slot == $past(push_slot) + 1'b1);
  // R4
  frame_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (msp_out == $past(push_addr) - TOP_OFS) ||
                    (psp_out == $past(push_addr) - TOP_OFS));
  // R6
  priv_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(privileged) |-> handler_mode);
  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_err |-> handler_mode == $past(handler_mode));
  // R10
  tail_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tail_chain |=> !busy && handler_mode);
  // R12
  sp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msp_out[1:0] == 2'b00 && psp_out[1:0] == 2'b00);
endmodule

bind exc_sp_ctrl exc_sp_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .take_exc(take_exc), .tail_chain(tail_chain),
  .busy(busy), .push_slot(push_slot), .push_addr(push_addr),
  .handler_mode(handler_mode), .privileged(privileged), .sp_active(sp_active),
  .msp_out(msp_out), .psp_out(psp_out), .ret_err(ret_err)
);

// File: tb/exc_sp_ctrl_test.sv
`timescale 1ns/1ps
module exc_sp_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_req = 1'b0, ret_req = 1'b0, ctl_we = 1'b0, msp_we = 1'b0, psp_we = 1'b0;
  logic [1:0]  ret_code = 2'b00, ctl_wdata = 2'b00;
  logic [31:0] sp_wdata = '0;
  logic [31:0] msp_out, psp_out, sp_active, push_addr;
  logic        handler_mode, privileged, busy, push_we, ret_err;
  logic [2:0]  push_slot;

  int n_chk = 0, n_fail = 0;
  logic [31:0] msp_m = 32'h2000_0400, psp_m = 32'h0;
  logic act_psp = 1'b0;

  always #2.5 clk = ~clk;

  exc_sp_ctrl uut (
    .clk, .rst_n, .exc_req, .ret_req, .ret_code, .ctl_we, .ctl_wdata,
    .msp_we, .psp_we, .sp_wdata, .msp_out, .psp_out, .sp_active,
    .handler_mode, .privileged, .busy, .push_we, .push_addr, .push_slot, .ret_err
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // op encoding: 0 control write, 1 return, 2 exception; then {handler, priv, process-active, err}
  localparam int NV = 13;
  localparam logic [7:0] VEC [NV] = '{
    8'b00_10_0110, 8'b10_00_1100, 8'b01_11_1101, 8'b01_10_0110,
    8'b00_11_0010, 8'b00_00_0010, 8'b10_00_1100, 8'b00_00_1100,
    8'b01_01_0100, 8'b10_00_1100, 8'b10_00_1100, 8'b01_00_1100,
    8'b01_01_0100
  };

  // take one exception; optionally raise extra requests during stacking
  task automatic do_exc(input logic on_psp, input int late_at, input int ret_at);
    logic [31:0] base;
    base = (on_psp ? psp_m : msp_m) - 32'd32;
    @(negedge clk) exc_req = 1'b1;
    @(negedge clk) exc_req = 1'b0;
    for (int k = 0; k < 8; k++) begin
      chk("R3 busy", {31'b0, busy}, 32'd1);
      chk("R3 push_we", {31'b0, push_we}, 32'd1);
      chk("R3 slot", {29'b0, push_slot}, 32'(k));
      chk("R3 addr", push_addr, base + 32'(4 * k));
      exc_req  = (k == late_at);
      ret_req  = (k == ret_at);
      ret_code = 2'b01;
      @(negedge clk);
    end
    exc_req = 1'b0; ret_req = 1'b0;
    chk("R4 busy low", {31'b0, busy}, 32'd0);
    if (on_psp) begin
      chk("R4 psp", psp_out, base); chk("R4 msp kept", msp_out, msp_m); psp_m = base;
    end else begin
      chk("R4 msp", msp_out, base); chk("R4 psp kept", psp_out, psp_m); msp_m = base;
    end
  endtask

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 handler", {31'b0, handler_mode}, 32'd0);
    chk("R1 priv", {31'b0, privileged}, 32'd1);
    chk("R1 sp_active", sp_active, 32'h2000_0400);
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 push_we", {31'b0, push_we}, 32'd0);
    chk("R1 ret_err", {31'b0, ret_err}, 32'd0);

    // R12 load process pointer through its port
    psp_we = 1'b1; sp_wdata = 32'h1000_0800;
    @(negedge clk) psp_we = 1'b0;
    psp_m = 32'h1000_0800;
    chk("R12 psp read", psp_out, psp_m);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] v;
      v = VEC[i];
      case (v[7:6])
        2'd0: begin
          ctl_we = 1'b1; ctl_wdata = v[5:4];
          @(negedge clk) ctl_we = 1'b0;
        end
        2'd1: begin
          ret_req = 1'b1; ret_code = v[5:4];
          @(negedge clk) ret_req = 1'b0;
        end
        default: do_exc(act_psp, -1, -1);
      endcase
      chk("R2 R7 handler", {31'b0, handler_mode}, {31'b0, v[3]});
      chk("R5 R6 priv", {31'b0, privileged}, {31'b0, v[2]});
      chk("R5 active sp", sp_active, v[1] ? psp_m : msp_m);
      chk("R8 ret_err", {31'b0, ret_err}, {31'b0, v[0]});
      act_psp = v[1];
    end

    // R12 alignment of written values
    msp_we = 1'b1; sp_wdata = 32'h2000_0413;
    @(negedge clk) msp_we = 1'b0;
    msp_m = 32'h2000_0410;
    chk("R12 msp aligned", msp_out, msp_m);
    psp_we = 1'b1; sp_wdata = 32'h1000_0902;
    @(negedge clk) psp_we = 1'b0;
    psp_m = 32'h1000_0900;
    chk("R12 psp aligned", psp_out, psp_m);

    // R9 late-arriving request during stacking
    do_exc(1'b0, 3, -1);
    @(negedge clk);
    chk("R9 no new frame", {31'b0, busy}, 32'd0);
    chk("R9 push idle", {31'b0, push_we}, 32'd0);
    chk("R9 msp single drop", msp_out, msp_m);

    // R10 tail-chain: exception with return in same cycle
    exc_req = 1'b1; ret_req = 1'b1; ret_code = 2'b01;
    @(negedge clk) begin exc_req = 1'b0; ret_req = 1'b0; end
    chk("R10 no stacking", {31'b0, busy}, 32'd0);
    chk("R10 handler kept", {31'b0, handler_mode}, 32'd1);
    @(negedge clk);
    chk("R10 still idle", {31'b0, push_we}, 32'd0);
    chk("R10 msp kept", msp_out, msp_m);

    // R11 return held during stacking
    do_exc(1'b0, -1, 2);
    chk("R11 handler first idle cycle", {31'b0, handler_mode}, 32'd1);
    @(negedge clk);
    chk("R11 held return applied", {31'b0, handler_mode}, 32'd0);
    chk("R11 main active", sp_active, msp_m);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule